// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This block counts what happens inside a processor. It has one cycle counter that runs on the clock and two event counters. Each event counter takes an 8-bit event code from the control register. The code picks one line of an external strobe vector, and the counter adds one on every clock where that line is high. The event strobes arrive as plain inputs from the surrounding logic.

Software reaches the unit through a small register port with four indexes. Index 0 is a packed control word. It holds the global run bit, two self-clearing counter-reset bits, a slow mode for the cycle counter, the interrupt enables, the sticky wrap flags and both event codes. Indexes 1 to 3 read and write the counters directly. Any enabled wrap flag raises a single level interrupt. The interrupt stays high until software writes a one to that flag.

Top module: `perf_mon_unit`

## Requirements
- R1: After reset all three counters read 0, the interrupt is low, and the control word reads 0x0FFFF000: run, slow mode, enables and flags are all 0, and both event codes are 0xFF.
- R2: Read data is registered. The value at the index applied before a rising edge appears on `reg_rdata_o` after that edge. Index 0 is control, index 1 is the cycle counter, index 2 is event counter 0 and index 3 is event counter 1. A write to indexes 1 to 3 loads that counter with the write data.
- R3: A counter advances only on edges where the run bit (control bit 0) is 1. While bit 3 is 0, the cycle counter adds one on every such edge. With run at 0 every counter holds its value.
- R4: With control bit 3 set, the cycle counter adds one once per 64 edges with run at 1.
- R5: Event counter 0 takes its code from control bits 19:12 and event counter 1 from bits 27:20. A counter with a valid code adds one on each running edge where `event_strobe_i[code]` is high.
- R6: Only codes 0x00–0x0D, 0x10–0x12 and 0x14–0x16 count. Code 0xFF, the holes 0x0E, 0x0F and 0x13, and all other codes never advance their counter.
- R7: A control write with bit 1 set clears both event counters. With bit 2 set it clears the cycle counter and its divide-by-64 phase. Both bits always read back as 0.
- R8: A counter that steps from 0xFFFFFFFF to 0 sets its wrap flag on the same edge. The flag for event counter 0 is bit 8, for event counter 1 bit 9, and for the cycle counter bit 10.
- R9: Wrap flags are sticky. A control write with a 1 in a flag bit clears that flag, and a 0 leaves it alone. A wrap on one counter never clears another counter's flag, and a wrap on the same edge as a clear leaves the flag set.
- R10: `irq_o` is a register. It goes high one edge after any flag is set together with its enable, and low one edge after no such pair remains. The enables are bit 4 for event counter 0, bit 5 for event counter 1 and bit 6 for the cycle counter.
- R11: A direct counter write on an edge where that counter would also advance loads the written value, with no increment.
- R12: Control bits 7, 11 and 31:28 ignore writes and always read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr_i | input | 2 | Register index (0 control, 1 cycle, 2 event 0, 3 event 1) |
| reg_wr_i | input | 1 | Write strobe for the indexed register |
| reg_wdata_i | input | 32 | Write data |
| event_strobe_i | input | NUM_STROBES | Event strobes, one line per event code |
| reg_rdata_o | output | 32 | Registered read data of the indexed register |
| irq_o | output | 1 | Level interrupt: any enabled wrap flag set |

## Verification
The hard case to reach from the ports is a counter wrap. A wrap needs 2^32 events, and R9 also calls for flags that collide across counters. The stimulus preloads a counter to one or two counts below the top through its direct write index. It then opens the run bit for exactly the number of edges that forces the wrap.

A second counter is wrapped the same way while the first flag is still set. This shows that the new wrap leaves the old flag alone. Clearing one flag with a write-one then shows that the other flag survives. The interrupt is sampled just before and just after its register edge.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int DATA_W   = 32;
  localparam int CODE_W   = 8;
  localparam int NUM_CTR  = 3;   // 0: event 0, 1: event 1, 2: cycle

  // control word bit positions (software-visible layout)
  localparam int B_RUN    = 0;
  localparam int B_CLR_EV = 1;
  localparam int B_CLR_CY = 2;
  localparam int B_SLOW   = 3;
  localparam int B_IEN    = 4;   // 3 bits: ev0, ev1, cyc
  localparam int B_FLAG   = 8;   // 3 bits: ev0, ev1, cyc
  localparam int B_SEL0   = 12;
  localparam int B_SEL1   = 20;

  typedef enum logic [1:0] {
    IDX_CTRL = 2'd0,
    IDX_CYC  = 2'd1,
    IDX_EV0  = 2'd2,
    IDX_EV1  = 2'd3
  } reg_idx_e;

  // codes that map to a real event source
  function automatic bit code_counts(int c);
    return (c >= 0 && c <= 'h0D) || (c >= 'h10 && c <= 'h16 && c != 'h13);
  endfunction
endpackage

// File: rtl/pmu_event_sel.sv
module pmu_event_sel #(
  parameter int NUM_STROBES = 32,
  parameter int CODE_W      = 8
) (
  input  logic [CODE_W-1:0]      code,
  input  logic [NUM_STROBES-1:0] strobes,
  output logic                   hit
);
  logic [NUM_STROBES-1:0] match;

  for (genvar i = 0; i < NUM_STROBES; i++) begin : g_dec
    if (pmu_pkg::code_counts(i)) begin : g_live
      assign match[i] = (code == CODE_W'(i));
    end else begin : g_dead
      assign match[i] = 1'b0;
    end
  end

  assign hit = |(match & strobes);

  // at most one source line can be steering a counter (R5)
  always_comb begin
    assert_single_source_R5: assert ($onehot0(match));
  end
endmodule

// File: rtl/pmu_prescaler.sv
module pmu_prescaler #(
  parameter int LOG2 = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic tick,
  output logic pulse
);
  logic [LOG2-1:0] phase;

  assign pulse = tick && !clear && (&phase);

  always_ff @(posedge clk) begin
    if (rst || clear) phase <= '0;
    else if (tick)    phase <= phase + 1'b1;
  end

  // slow mode never advances the counter on two edges in a row (R4)
  assert_no_back_to_back_R4: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);
endmodule

// File: rtl/pmu_counter.sv
module pmu_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         clear,
  input  logic         inc,
  output logic [W-1:0] count,
  output logic         wrap
);
  assign wrap = inc && !load && !clear && (&count);

  always_ff @(posedge clk) begin
    if (rst)        count <= '0;
    else if (load)  count <= load_val;
    else if (clear) count <= '0;
    else if (inc)   count <= count + 1'b1;
  end

  assert_load_wins_R11: assert property (@(posedge clk) disable iff (rst)
    load |=> count == $past(load_val));

  assert_wrap_to_zero_R8: assert property (@(posedge clk) disable iff (rst)
    wrap |=> count == '0);
endmodule

// File: rtl/perf_mon_unit.sv
module perf_mon_unit #(
  parameter int CNT_W         = 32,
  parameter int NUM_STROBES   = 32,
  parameter int PRESCALE_LOG2 = 6
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [1:0]                    reg_addr_i,
  input  logic                          reg_wr_i,
  input  logic [pmu_pkg::DATA_W-1:0]    reg_wdata_i,
  input  logic [NUM_STROBES-1:0]        event_strobe_i,
  output logic [pmu_pkg::DATA_W-1:0]    reg_rdata_o,
  output logic                          irq_o
);
  import pmu_pkg::*;

  localparam int NC = NUM_CTR;
  localparam int CYC = NC - 1;

  // control state
  logic                   run_q, slow_q;
  logic [NC-1:0]          ien_q, flag_q;
  logic [1:0][CODE_W-1:0] sel_q;

  logic                   ctrl_wr;
  logic [NC-1:0]          ctr_load, ctr_clr, ctr_inc, ctr_wrap;
  logic [NC-1:0][CNT_W-1:0] ctr_val;
  logic [1:0]             ev_hit;
  logic                   slow_pulse;
  logic [NC-1:0]          flag_wclr;
  logic [DATA_W-1:0]      ctrl_view;

  assign ctrl_wr   = reg_wr_i && (reg_addr_i == IDX_CTRL);
  assign flag_wclr = ctrl_wr ? reg_wdata_i[B_FLAG +: NC] : '0;

  // event source selection
  for (genvar e = 0; e < 2; e++) begin : g_sel
    pmu_event_sel #(.NUM_STROBES(NUM_STROBES), .CODE_W(CODE_W)) u_sel (
      .code    (sel_q[e]),
      .strobes (event_strobe_i),
      .hit     (ev_hit[e])
    );
  end

  pmu_prescaler #(.LOG2(PRESCALE_LOG2)) u_div (
    .clk   (clk),
    .rst   (rst),
    .clear (ctr_clr[CYC]),
    .tick  (run_q && slow_q),
    .pulse (slow_pulse)
  );

  // per-counter steering
  for (genvar k = 0; k < NC; k++) begin : g_ctr
    if (k == CYC) begin : g_cyc
      assign ctr_load[k] = reg_wr_i && (reg_addr_i == IDX_CYC);
      assign ctr_clr[k]  = ctrl_wr && reg_wdata_i[B_CLR_CY];
      assign ctr_inc[k]  = run_q && (slow_q ? slow_pulse : 1'b1);
    end else begin : g_evt
      assign ctr_load[k] = reg_wr_i && (reg_addr_i == ((k == 0) ? IDX_EV0 : IDX_EV1));
      assign ctr_clr[k]  = ctrl_wr && reg_wdata_i[B_CLR_EV];
      assign ctr_inc[k]  = run_q && ev_hit[k];
    end

    pmu_counter #(.W(CNT_W)) u_ctr (
      .clk      (clk),
      .rst      (rst),
      .load     (ctr_load[k]),
      .load_val (reg_wdata_i[CNT_W-1:0]),
      .clear    (ctr_clr[k]),
      .inc      (ctr_inc[k]),
      .count    (ctr_val[k]),
      .wrap     (ctr_wrap[k])
    );

    assert_wrap_sets_flag_R8: assert property (@(posedge clk) disable iff (rst)
      ctr_wrap[k] |=> flag_q[k]);

    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (rst)
      $past(flag_q[k]) && !($past(ctrl_wr) && $past(reg_wdata_i[B_FLAG + k]))
      |-> flag_q[k]);

    assert_hold_when_stopped_R3: assert property (@(posedge clk) disable iff (rst)
      !$past(run_q) && !$past(ctr_load[k]) && !$past(ctr_clr[k])
      |-> $stable(ctr_val[k]));
  end

  // event counters with a dead code never move (R6)
  for (genvar e = 0; e < 2; e++) begin : g_dead_chk
    assert_dead_code_R6: assert property (@(posedge clk) disable iff (rst)
      !code_counts(int'($past(sel_q[e]))) && !$past(ctr_load[e]) && !$past(ctr_clr[e])
      |-> $stable(ctr_val[e]));
  end

  // control register
  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      slow_q <= 1'b0;
      ien_q  <= '0;
      flag_q <= '0;
      sel_q  <= {2{{CODE_W{1'b1}}}};
    end else begin
      if (ctrl_wr) begin
        run_q    <= reg_wdata_i[B_RUN];
        slow_q   <= reg_wdata_i[B_SLOW];
        ien_q    <= reg_wdata_i[B_IEN +: NC];
        sel_q[0] <= reg_wdata_i[B_SEL0 +: CODE_W];
        sel_q[1] <= reg_wdata_i[B_SEL1 +: CODE_W];
      end
      // a wrap on the same edge as a clear keeps the flag
      flag_q <= (flag_q & ~flag_wclr) | ctr_wrap;
    end
  end

  always_comb begin
    ctrl_view = '0;
    ctrl_view[B_RUN]              = run_q;
    ctrl_view[B_SLOW]             = slow_q;
    ctrl_view[B_IEN +: NC]        = ien_q;
    ctrl_view[B_FLAG +: NC]       = flag_q;
    ctrl_view[B_SEL0 +: CODE_W]   = sel_q[0];
    ctrl_view[B_SEL1 +: CODE_W]   = sel_q[1];
  end

  // registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata_o <= '0;
      irq_o       <= 1'b0;
    end else begin
      unique case (reg_idx_e'(reg_addr_i))
        IDX_CTRL: reg_rdata_o <= ctrl_view;
        IDX_CYC:  reg_rdata_o <= DATA_W'(ctr_val[CYC]);
        IDX_EV0:  reg_rdata_o <= DATA_W'(ctr_val[0]);
        IDX_EV1:  reg_rdata_o <= DATA_W'(ctr_val[1]);
      endcase
      irq_o <= |(flag_q & ien_q);
    end
  end

  assert_reserved_zero_R12: assert property (@(posedge clk) disable iff (rst)
    $past(reg_addr_i) == IDX_CTRL
    |-> reg_rdata_o[31:28] == 4'd0 && !reg_rdata_o[11] && !reg_rdata_o[7]);

  assert_reset_bits_read_zero_R7: assert property (@(posedge clk) disable iff (rst)
    $past(reg_addr_i) == IDX_CTRL |-> reg_rdata_o[2:1] == 2'b00);

  assert_irq_has_source_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> $past(|flag_q));
endmodule

// File: tb/test_perf_mon_unit.sv
module test_perf_mon_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  reg_addr_i = '0;
  logic        reg_wr_i = 1'b0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] event_strobe_i = '0;
  logic [31:0] reg_rdata_o;
  logic        irq_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [32:0] exp_q[$];   // bit 32 set: irq check
  string       tag_q[$];
  event        mon_ev;

  always #2.5 clk = ~clk;   // 200 MHz

  perf_mon_unit i_perf_mon_unit (
    .clk(clk), .rst(rst), .reg_addr_i(reg_addr_i), .reg_wr_i(reg_wr_i),
    .reg_wdata_i(reg_wdata_i), .event_strobe_i(event_strobe_i),
    .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
  );

  // control word builder; ien/flg are {cyc, ev1, ev0}
  function automatic logic [31:0] cv(bit run, bit slow, logic [2:0] ien,
                                     logic [2:0] flg, logic [7:0] s0, logic [7:0] s1);
    return {4'd0, s1, s0, 1'b0, flg, 1'b0, ien, slow, 2'b00, run};
  endfunction

  // monitor: pops expected items and compares
  initial begin
    forever begin
      @(mon_ev);
      while (exp_q.size() > 0) begin
        logic [32:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (e[32]) begin
          if (irq_o !== e[0]) begin
            failures++;
            $display("FAIL %s irq actual=%0b expected=%0b", t, irq_o, e[0]);
          end
        end else if (reg_rdata_o !== e[31:0]) begin
          failures++;
          $display("FAIL %s rdata actual=%h expected=%h", t, reg_rdata_o, e[31:0]);
        end
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_addr_i = a; reg_wdata_i = d; reg_wr_i = 1'b1;
    @(negedge clk);
    reg_wr_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string t);
    reg_addr_i = a; reg_wr_i = 1'b0;
    exp_q.push_back({1'b0, exp}); tag_q.push_back(t);
    @(posedge clk); #1;
    -> mon_ev;
    wait (exp_q.size() == 0);
    @(negedge clk);
  endtask

  task automatic chk_irq(input bit exp, input string t);
    exp_q.push_back({1'b1, 31'd0, exp}); tag_q.push_back(t);
    -> mon_ev;
    wait (exp_q.size() == 0);
  endtask

  initial begin
    #(5ns * 200000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(0, 32'h0FFF_F000, "R1 ctrl");
    rd(1, 0, "R1 cyc");
    rd(2, 0, "R1 ev0");
    rd(3, 0, "R1 ev1");
    chk_irq(0, "R1 irq");

    // R12 / R7: all-ones write, reserved and reset bits read 0
    wr(0, 32'hFFFF_FFFF);
    rd(0, 32'h0FFF_F079, "R12 ctrl all-ones");
    wr(0, 32'h0);
    rd(1, 0, "R4 fewer than 64 slow ticks");

    // R3 run gating
    wr(0, cv(1, 0, 0, 0, 8'hFF, 8'hFF));
    idle(9);
    wr(0, cv(0, 0, 0, 0, 8'hFF, 8'hFF));
    rd(1, 10, "R3 cyc after 10 edges");
    idle(5);
    rd(1, 10, "R3 cyc frozen");

    // R2 direct access
    wr(2, 32'h1234_5678);
    wr(3, 32'hCAFE_0001);
    rd(2, 32'h1234_5678, "R2 ev0");
    rd(3, 32'hCAFE_0001, "R2 ev1");
    rd(1, 10, "R2 cyc");

    // R7 reset bits
    wr(0, cv(0, 0, 0, 0, 8'hFF, 8'hFF) | 32'h2);
    rd(2, 0, "R7 ev0 cleared");
    rd(3, 0, "R7 ev1 cleared");
    rd(1, 10, "R7 cyc kept");
    wr(0, cv(0, 0, 0, 0, 8'hFF, 8'hFF) | 32'h4);
    rd(1, 0, "R7 cyc cleared");

    // R5 event steering
    event_strobe_i = 32'h0000_0088;      // lines 7 and 3
    wr(0, cv(1, 0, 0, 0, 8'h07, 8'h0B));
    idle(4);
    wr(0, cv(0, 0, 0, 0, 8'h07, 8'h0B));
    rd(2, 5, "R5 ev0 code 07");
    rd(3, 0, "R5 ev1 code 0B idle");
    event_strobe_i = 32'h0000_0800;      // line 11
    wr(0, cv(1, 0, 0, 0, 8'h07, 8'h0B));
    idle(2);
    wr(0, cv(0, 0, 0, 0, 8'h07, 8'h0B));
    rd(2, 5, "R5 ev0 held");
    rd(3, 3, "R5 ev1 code 0B");
    rd(1, 8, "R3 cyc total");

    // R6 dead codes
    event_strobe_i = 32'hFFFF_FFFF;
    wr(0, cv(0, 0, 0, 0, 8'h0E, 8'h13) | 32'h6);
    wr(0, cv(1, 0, 0, 0, 8'h0E, 8'h13));
    idle(3);
    wr(0, cv(0, 0, 0, 0, 8'h0E, 8'h13));
    rd(2, 0, "R6 code 0E");
    rd(3, 0, "R6 code 13");
    wr(0, cv(1, 0, 0, 0, 8'hFF, 8'h16));
    idle(3);
    wr(0, cv(0, 0, 0, 0, 8'hFF, 8'h16));
    rd(2, 0, "R6 code FF");
    rd(3, 4, "R5 code 16");
    event_strobe_i = '0;

    // R4 slow cycle mode
    wr(0, cv(0, 1, 0, 0, 8'hFF, 8'hFF) | 32'h4);
    wr(0, cv(1, 1, 0, 0, 8'hFF, 8'hFF));
    idle(128);
    wr(0, cv(0, 1, 0, 0, 8'hFF, 8'hFF));
    rd(1, 2, "R4 129 edges");

    // R8 / R10 wrap on event 0
    wr(0, cv(0, 0, 3'b001, 0, 8'h07, 8'hFF));
    wr(2, 32'hFFFF_FFFE);
    event_strobe_i = 32'h0000_0080;
    wr(0, cv(1, 0, 3'b001, 0, 8'h07, 8'hFF));
    idle(1);
    wr(0, cv(0, 0, 3'b001, 0, 8'h07, 8'hFF));
    event_strobe_i = '0;
    rd(2, 0, "R8 ev0 wrapped");
    rd(0, cv(0, 0, 3'b001, 3'b001, 8'h07, 8'hFF), "R8 ev0 flag");
    chk_irq(1, "R10 irq ev0");

    // R9 second wrap keeps first flag
    wr(1, 32'hFFFF_FFFF);
    wr(0, cv(1, 0, 3'b001, 0, 8'h07, 8'hFF));
    wr(0, cv(0, 0, 3'b001, 0, 8'h07, 8'hFF));
    rd(0, cv(0, 0, 3'b001, 3'b101, 8'h07, 8'hFF), "R9 both flags");
    wr(0, cv(0, 0, 3'b001, 3'b001, 8'h07, 8'hFF));
    rd(0, cv(0, 0, 3'b001, 3'b100, 8'h07, 8'hFF), "R9 clear one");
    chk_irq(0, "R10 irq masked");
    wr(0, cv(0, 0, 3'b100, 0, 8'h07, 8'hFF));
    chk_irq(0, "R10 irq one edge late");
    idle(1);
    chk_irq(1, "R10 irq cyc");

    // R11 load beats increment
    wr(0, cv(1, 0, 3'b100, 0, 8'h07, 8'hFF));
    wr(1, 32'd100);
    wr(0, cv(0, 0, 3'b000, 3'b100, 8'h07, 8'hFF));
    rd(1, 101, "R11 load wins");
    chk_irq(0, "R10 irq after clear");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule